// File: doc/BRIEF.md
# DMA Shared Done-Pin Channel Logic

This block controls the single active-low transfer-done pin shared by a four-channel DMA engine. Every channel has a two-bit done-mode field. This field decides whether the channel drives the pin to announce completion, watches the pin as an early-stop request from an external device, does both, or ignores the pin. The pin always belongs to whichever channel's acknowledge strobe is active. Outside the acknowledge cycles of a channel, the pin has no meaning for that channel.

The output side is combinational. It pulls the pin low during the acknowledge cycle of the last transfer, in one of two ways. With the channel's chain-end bit clear, it does so for every descriptor. With the chain-end bit set, it does so only on the last descriptor of the linked chain. The input side first passes the pin through a two-flop synchronizer. It delays the acknowledge by the same two stages so that both are sampled on the same edge. A small state machine then turns a qualified external assertion into one-cycle pulses. These are a terminate request and status-set strobes, and the transfer engine uses them to end either the current descriptor or the whole chain.

The state machine has three states. ST_IDLE means no termination is pending. ST_END_DESC issues the pulses that end one descriptor. ST_END_CHAIN issues the pulses that end the whole chain. The transitions are as follows:
- From any state, a qualified hit moves the machine to ST_END_CHAIN when the hit channel's chain-end bit is set.
- From any state, a qualified hit moves the machine to ST_END_DESC when that bit is clear.
- With no hit, the machine returns to ST_IDLE.

Each END state therefore lasts exactly one cycle unless a new hit follows.

Top module: `dma_done_ctrl`

## Requirements
- R1: Mode field bits for channel n are done_mode[2n+1:2n]. Code 00 means the pin is unused. Code 01 means input only, 10 means output only, and 11 means both. Bit 1 enables driving the pin and bit 0 enables sampling it.
- R2: The pin is driven only in a cycle in which the acknowledge bit of an output-enabled channel is high. The pin is sampled only against the acknowledge of an input-enabled channel.
- R3: With chain_end[n]=1, channel n drives the pin only when last_xfer=1 and last_desc=1 during its acknowledge.
- R4: With chain_end[n]=0, channel n drives the pin whenever last_xfer=1 during its acknowledge, whatever the value of last_desc.
- R5: While the pin is driven, done_oe=1 and done_out_n=0 in the same cycle as the acknowledge. Otherwise done_oe=0 and done_out_n=1.
- R6: When done_in_n=0 is held during one acknowledge cycle of an input-enabled channel n, term_req[n] and flag_ext[n] are high in the cycle that begins at the third rising edge after that cycle started. Both are low one cycle earlier.
- R7: An external end with chain_end[n]=1 also pulses flag_xfer_end[n], flag_chain_end[n] and clr_active[n].
- R8: An external end with chain_end[n]=0 pulses flag_xfer_end[n] but leaves flag_chain_end[n] and clr_active[n] low.
- R9: A low pin with no acknowledge active, or during the acknowledge of a channel whose mode bit 0 is clear, produces no pulse.
- R10: Every pulse output lasts exactly one clock cycle.
- R11: After reset, done_oe=0, done_out_n=1 and every pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack | input | 4 | Per-channel acknowledge strobes, at most one high |
| last_xfer | input | 1 | Current acknowledged transfer is the last of its descriptor |
| last_desc | input | 1 | Current descriptor is the last in its chain |
| done_mode | input | 8 | Two-bit done-mode field per channel |
| chain_end | input | 4 | Per-channel chain-end select |
| done_in_n | input | 1 | Pin level as seen from outside, asynchronous |
| done_out_n | output | 1 | Pin drive level, active low |
| done_oe | output | 1 | Pin output enable |
| term_req | output | 4 | Per-channel terminate pulse |
| flag_ext | output | 4 | Set pulse for external-done status |
| flag_xfer_end | output | 4 | Set pulse for normal transfer-end status |
| flag_chain_end | output | 4 | Set pulse for normal chain-end status |
| clr_active | output | 4 | Pulse clearing the channel's transfer-active bit |

## Verification
The output drive for one channel can fall in the same cycle as the termination pulses for another channel. The pulses come from an external done that was captured three edges earlier. The bench provokes this as follows. Channel 2, set to input mode, receives an external done. Exactly when its pulses are due, channel 0, set to output mode, is acknowledged with last_xfer high. The bench then checks that done_oe and flag_ext[2] are both high in that one cycle, and that no pulse leaks onto channel 0.

// File: rtl/dmadn_pkg.sv
package dmadn_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_END_DESC  = 2'd1,
        ST_END_CHAIN = 2'd2
    } dn_state_e;

    localparam int MODE_BIT_IN  = 0;
    localparam int MODE_BIT_OUT = 1;

endpackage

// File: rtl/dmadn_align.sv
module dmadn_align #(
    parameter int NCH    = 4,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pin_n,
    input  logic [NCH-1:0] ack,
    output logic           pin_sync_n,
    output logic [NCH-1:0] ack_al
);
    logic [STAGES-1:0] pin_q;
    logic [NCH-1:0]    ack_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '1;
            for (int k = 0; k < STAGES; k++) ack_q[k] <= '0;
        end else begin
            pin_q    <= {pin_q[STAGES-2:0], pin_n};
            ack_q[0] <= ack;
            for (int k = 1; k < STAGES; k++) ack_q[k] <= ack_q[k-1];
        end
    end

    assign pin_sync_n = pin_q[STAGES-1];
    assign ack_al     = ack_q[STAGES-1];

endmodule

// File: rtl/dmadn_drive.sv
module dmadn_drive #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] ack,
    input  logic [NCH-1:0] out_en,
    input  logic [NCH-1:0] chain_end,
    input  logic           last_xfer,
    input  logic           last_desc,
    output logic           drive
);
    always_comb begin
        drive = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (ack[i] && out_en[i] && last_xfer && (!chain_end[i] || last_desc))
                drive = 1'b1;
        end
    end
endmodule

// File: rtl/dmadn_term.sv
module dmadn_term
    import dmadn_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ack_al,
    input  logic           pin_sync_n,
    input  logic [NCH-1:0] in_en,
    input  logic [NCH-1:0] chain_end,
    output logic [NCH-1:0] term_req,
    output logic [NCH-1:0] flag_ext,
    output logic [NCH-1:0] flag_xfer_end,
    output logic [NCH-1:0] flag_chain_end,
    output logic [NCH-1:0] clr_active
);
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

    dn_state_e     state, state_nx;
    logic [CW-1:0] ch_q, ch_nx;
    logic          hit;

    always_comb begin
        hit   = 1'b0;
        ch_nx = ch_q;
        for (int i = 0; i < NCH; i++) begin
            if (ack_al[i] && in_en[i] && !pin_sync_n) begin
                hit   = 1'b1;
                ch_nx = CW'(i);
            end
        end
        if (!hit)                  state_nx = ST_IDLE;
        else if (chain_end[ch_nx]) state_nx = ST_END_CHAIN;
        else                       state_nx = ST_END_DESC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ch_q  <= '0;
        end else begin
            state <= state_nx;
            ch_q  <= ch_nx;
        end
    end

    always_comb begin
        term_req       = '0;
        flag_ext       = '0;
        flag_xfer_end  = '0;
        flag_chain_end = '0;
        clr_active     = '0;
        unique case (state)
            ST_IDLE: ;
            ST_END_DESC: begin
                term_req[ch_q]      = 1'b1;
                flag_ext[ch_q]      = 1'b1;
                flag_xfer_end[ch_q] = 1'b1;
            end
            ST_END_CHAIN: begin
                term_req[ch_q]       = 1'b1;
                flag_ext[ch_q]       = 1'b1;
                flag_xfer_end[ch_q]  = 1'b1;
                flag_chain_end[ch_q] = 1'b1;
                clr_active[ch_q]     = 1'b1;
            end
            default: ;
        endcase
    end

    assert_one_channel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(term_req));

    assert_chain_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_chain_end) |-> (flag_chain_end == clr_active && flag_chain_end == flag_xfer_end));

    assert_desc_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_xfer_end & ~flag_chain_end)) |-> (clr_active == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        assert_term_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
            term_req[g] |-> $past(ack_al[g] && in_en[g] && !pin_sync_n));
    end

endmodule

// File: rtl/dma_done_ctrl.sv
module dma_done_ctrl #(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   ack,
    input  logic             last_xfer,
    input  logic             last_desc,
    input  logic [2*NCH-1:0] done_mode,
    input  logic [NCH-1:0]   chain_end,
    input  logic             done_in_n,
    output logic             done_out_n,
    output logic             done_oe,
    output logic [NCH-1:0]   term_req,
    output logic [NCH-1:0]   flag_ext,
    output logic [NCH-1:0]   flag_xfer_end,
    output logic [NCH-1:0]   flag_chain_end,
    output logic [NCH-1:0]   clr_active
);
    import dmadn_pkg::*;

    logic [NCH-1:0] in_en, out_en, ack_al;
    logic           pin_sync_n, drive;

    for (genvar g = 0; g < NCH; g++) begin : g_mode
        assign in_en[g]  = done_mode[2*g + MODE_BIT_IN];
        assign out_en[g] = done_mode[2*g + MODE_BIT_OUT];
    end

    dmadn_align #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_align (
        .clk(clk), .rst_n(rst_n), .pin_n(done_in_n), .ack(ack),
        .pin_sync_n(pin_sync_n), .ack_al(ack_al)
    );

    dmadn_drive #(.NCH(NCH)) u_drive (
        .ack(ack), .out_en(out_en), .chain_end(chain_end),
        .last_xfer(last_xfer), .last_desc(last_desc), .drive(drive)
    );

    dmadn_term #(.NCH(NCH)) u_term (
        .clk(clk), .rst_n(rst_n), .ack_al(ack_al), .pin_sync_n(pin_sync_n),
        .in_en(in_en), .chain_end(chain_end), .term_req(term_req),
        .flag_ext(flag_ext), .flag_xfer_end(flag_xfer_end),
        .flag_chain_end(flag_chain_end), .clr_active(clr_active)
    );

    assign done_oe    = drive;
    assign done_out_n = !drive;

    assert_oe_needs_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_oe |-> (|(ack & out_en)));

    assert_oe_last_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_oe |-> last_xfer);

    assert_pin_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_oe != done_out_n);

endmodule

// File: tb/tb_dma_done_ctrl.sv
module tb_dma_done_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    // {ch[1:0], mode[1:0], chain, last_xfer, last_desc, pin_low,
    //  exp_oe, exp_term, exp_ext, exp_xend, exp_cend, exp_clr, 2'b00}
    localparam int NVEC = 12;
    localparam logic [15:0] VEC [NVEC] = '{
        16'b00_10_0_1_0_0_1_0_0_0_0_0_00, // R4 per-descriptor drive
        16'b01_10_1_1_0_0_0_0_0_0_0_0_00, // R3 no drive before last descriptor
        16'b01_10_1_1_1_0_1_0_0_0_0_0_00, // R3 drive on last descriptor
        16'b10_01_0_1_1_1_0_1_1_1_0_0_00, // R1 input only, R8 descriptor end
        16'b11_01_1_0_0_1_0_1_1_1_1_1_00, // R7 chain end
        16'b00_11_0_1_0_1_1_1_1_1_0_0_00, // R1 both, R8
        16'b10_00_0_1_1_1_0_0_0_0_0_0_00, // R1 unused: nothing
        16'b11_10_0_0_1_1_0_0_0_0_0_0_00, // R9 output-only ignores pin
        16'b01_11_1_1_1_1_1_1_1_1_1_1_00, // R1 both, R7
        16'b00_10_0_0_0_0_0_0_0_0_0_0_00, // R4 not last transfer
        16'b10_10_0_1_1_0_1_0_0_0_0_0_00, // R4 last_desc irrelevant
        16'b11_11_1_1_0_1_0_1_1_1_1_1_00  // R3 no drive, R7 chain end
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   ack = '0;
    logic             last_xfer = 1'b0, last_desc = 1'b0;
    logic [2*NCH-1:0] done_mode = '0;
    logic [NCH-1:0]   chain_end = '0;
    logic             done_in_n = 1'b1;
    logic             done_out_n, done_oe;
    logic [NCH-1:0]   term_req, flag_ext, flag_xfer_end, flag_chain_end, clr_active;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_done_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ack(ack), .last_xfer(last_xfer),
        .last_desc(last_desc), .done_mode(done_mode), .chain_end(chain_end),
        .done_in_n(done_in_n), .done_out_n(done_out_n), .done_oe(done_oe),
        .term_req(term_req), .flag_ext(flag_ext), .flag_xfer_end(flag_xfer_end),
        .flag_chain_end(flag_chain_end), .clr_active(clr_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] pulses();
        return {term_req, flag_ext, flag_xfer_end, flag_chain_end, clr_active};
    endfunction

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #(CLK_PERIOD/4);
        chk("R11 oe", done_oe, 0);
        chk("R11 out_n", done_out_n, 1);
        chk("R11 pulses", pulses(), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] w;
            int c;
            logic [NCH-1:0] b;
            logic [19:0] expp;
            w = VEC[v];
            c = int'(w[15:14]);
            b = NCH'(1) << c;
            @(negedge clk);
            done_mode[2*c +: 2] = w[13:12];
            chain_end[c] = w[11];
            last_xfer = w[10];
            last_desc = w[9];
            done_in_n = !w[8];
            ack = b;
            #(CLK_PERIOD/4);
            chk("R5 drive oe", done_oe, w[7]);
            chk("R5 drive level", done_out_n, !w[7]);
            @(negedge clk);
            ack = '0; done_in_n = 1'b1; last_xfer = 0; last_desc = 0;
            @(negedge clk);
            chk("R6 no early pulse", pulses(), 0);
            @(negedge clk);
            expp = {w[6] ? b : 4'h0, w[5] ? b : 4'h0, w[4] ? b : 4'h0,
                    w[3] ? b : 4'h0, w[2] ? b : 4'h0};
            if (w[3]) chk("R7 chain-end pulses", pulses(), expp);
            else if (w[5]) chk("R8 descriptor-end pulses", pulses(), expp);
            else chk("R9 no pulses", pulses(), expp);
            @(negedge clk);
            chk("R10 single-cycle pulse", pulses(), 0);
        end

        // R9: pin low while no acknowledge is active
        @(negedge clk);
        done_mode = 8'hFF;
        done_in_n = 1'b0;
        @(negedge clk);
        done_in_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 pin without ack", pulses(), 0);

        // Concurrent: ch2 input pulses coincide with ch0 output drive
        done_mode = 8'b00_01_00_10;
        chain_end = '0;
        @(negedge clk);
        ack = 4'b0100; done_in_n = 1'b0;
        @(negedge clk);
        ack = '0; done_in_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        ack = 4'b0001; last_xfer = 1'b1;
        #(CLK_PERIOD/4);
        chk("R5 drive during pulse", done_oe, 1);
        chk("R6 ext pulse during drive", flag_ext, 4'b0100);
        chk("R8 term only ch2", term_req, 4'b0100);
        @(negedge clk);
        ack = '0; last_xfer = 1'b0;
        #(CLK_PERIOD/4);
        chk("R10 drive released", done_oe, 0);
        chk("R10 pulses cleared", pulses(), 0);

        finished = 1;
        finish_up();
    end
endmodule